// File: doc/BRIEF.md
# Address Bus Arbiter

This block decides which of several bus masters may drive the next address phase on a split-transaction address bus. Each master raises its own request line. The arbiter answers with one grant line per master. The shared start strobe tells it when the granted master has begun an address phase. The acknowledge input tells it when that phase has been accepted and is over.

Between the start strobe and the acknowledge, the address phase is in flight. During that time the arbiter keeps the grant on the master that owns the phase, and it never moves the grant to another master. If the acknowledge does not come in the cycle right after the start strobe, all grants drop and stay low until the acknowledge arrives. Once the phase is closed, a new owner is chosen in round-robin order. If nobody is asking for the bus, the grant stays parked on the last owner, so a lone master can start again without arbitration.

Top module: `addr_arbiter`

## Requirements
- R1: In every cycle, at most one bit of `bus_gnt` is high.
- R2: While `rst` is high at a clock edge, all state clears: `bus_gnt` is all zeros in the following cycle and the round-robin pointer is master 0. After reset, the first grant with no requests goes to master 0. If all masters request, the first grant goes to master 1.
- R3: After `xfer_start` is seen while master k holds the grant, no master other than k is granted until the cycle after `addr_ack` is seen.
- R4: If `addr_ack` is low in the cycle after `xfer_start`, `bus_gnt` is all zeros from the second cycle after `xfer_start` through the cycle in which `addr_ack` is high.
- R5: In the cycle right after `xfer_start`, the grant stays on the master that started the phase.
- R6: When the phase is closed at a clock edge and requests are present, the next grant goes to the first requester found by counting upward from the previous owner, wrapping from N-1 to 0. The previous owner itself is checked last.
- R7: When the phase is closed and no master requests, the grant parks on the previous owner.
- R8: A phase ends when `addr_ack` is high. Arbitration then happens at that cycle's edge, so a new owner can be granted in the very next cycle.
- R9: `xfer_start` in the same cycle as `addr_ack` opens a new phase. The grant stays with the current owner, and the delay rule of R4 restarts from that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | N | One request line per master |
| xfer_start | input | 1 | Shared strobe: the granted master begins an address phase |
| addr_ack | input | 1 | Acknowledge that ends the current address phase |
| bus_gnt | output | N | One grant line per master |

## Verification
Two things can land on the same clock edge: the acknowledge that closes a phase, and the round-robin choice of the next owner. A further case is a new start strobe in that same cycle, which competes with the handover. The random stimulus keeps other masters requesting while the acknowledge arrives, with delays from one to four cycles. The directed cases place an acknowledge right after the start strobe, and also a start strobe together with an acknowledge. Each cycle is judged two ways. A cycle-level model predicts the exact grant vector. Separate rule checks flag any grant to a non-owner inside an open phase, and any grant while the acknowledge is late.

// File: rtl/addr_arbiter.sv
module addr_arbiter #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] bus_req,
  input  logic         xfer_start,
  input  logic         addr_ack,
  output logic [N-1:0] bus_gnt
);

  localparam int W = (N > 1) ? $clog2(N) : 1;

  logic [W-1:0] owner_q;
  logic [W-1:0] next_owner;
  logic         live_q;
  logic         open_q;
  logic         late_q;
  logic         open_d;

  assign open_d = xfer_start | (open_q & ~addr_ack);

  always_comb begin
    logic found;
    int   idx;
    next_owner = owner_q;
    found      = 1'b0;
    for (int i = 1; i <= N; i++) begin
      idx = int'(owner_q) + i;
      if (idx >= N) idx = idx - N;
      if (!found && bus_req[idx]) begin
        next_owner = W'(idx);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
      live_q  <= 1'b0;
      open_q  <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      open_q <= open_d;
      late_q <= ~xfer_start & open_q & ~addr_ack;
      if (!open_d && (|bus_req)) owner_q <= next_owner;
    end
  end

  always_comb begin
    bus_gnt = '0;
    if (live_q && !late_q) bus_gnt[owner_q] = 1'b1;
  end

  p_excl_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_gnt));

  p_keep_owner_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && bus_gnt != '0) |=> (bus_gnt == '0 || bus_gnt == $past(bus_gnt)));

  p_late_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (open_q && !xfer_start && !addr_ack) |=> (bus_gnt == '0));

  p_park_r7: assert property (@(posedge clk) disable iff (rst)
    (!open_q && !xfer_start && bus_req == '0 && bus_gnt != '0) |=> (bus_gnt == $past(bus_gnt)));

endmodule

// File: tb/tb_addr_arbiter.sv
module tb_addr_arbiter;
  localparam int NM = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NM-1:0] bus_req = '0;
  logic          xfer_start = 1'b0;
  logic          addr_ack = 1'b0;
  logic [NM-1:0] bus_gnt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int  m_ptr;
  bit  m_live, m_open, m_late;
  int  b_owner, b_since, b_delay;
  bit  b_open;

  addr_arbiter #(.N(NM)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req),
    .xfer_start(xfer_start), .addr_ack(addr_ack), .bus_gnt(bus_gnt)
  );

  always #5 clk = ~clk;

  function automatic int rr_pick(int last, logic [NM-1:0] r);
    for (int i = 1; i <= NM; i++) begin
      int k;
      k = (last + i) % NM;
      if (r[k]) return k;
    end
    return last;
  endfunction

  function automatic logic [NM-1:0] expect_gnt();
    logic [NM-1:0] g;
    g = '0;
    if (m_live && !m_late) g[m_ptr] = 1'b1;
    return g;
  endfunction

  function automatic int gnt_index(logic [NM-1:0] g);
    for (int i = 0; i < NM; i++) if (g[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, logic [NM-1:0] act, logic [NM-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: bus_gnt=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic rules();
    checks++;
    if (!$onehot0(bus_gnt)) begin
      failures++;
      $display("FAIL R1: bus_gnt=%b expected at most one bit", bus_gnt);
    end
    checks++;
    if (b_open && bus_gnt != '0 && gnt_index(bus_gnt) != b_owner) begin
      failures++;
      $display("FAIL R3: bus_gnt=%b expected 0 or owner %0d", bus_gnt, b_owner);
    end
    checks++;
    if (b_open && b_since >= 2 && bus_gnt != '0) begin
      failures++;
      $display("FAIL R4: bus_gnt=%b expected 0 (ack late, %0d cycles)", bus_gnt, b_since);
    end
  endtask

  task automatic step(logic [NM-1:0] r, logic s, logic a, string tag);
    bit nopen;
    bus_req = r; xfer_start = s; addr_ack = a;
    if (rst) begin
      m_ptr = 0; m_live = 0; m_open = 0; m_late = 0;
      b_open = 0; b_since = 0;
    end else begin
      nopen  = s | (m_open & ~a);
      m_late = ~s & m_open & ~a;
      m_open = nopen;
      m_live = 1;
      if (!nopen && r != '0) m_ptr = rr_pick(m_ptr, r);
      if (s) begin
        b_owner = gnt_index(bus_gnt);
        b_open  = 1;
        b_since = 1;
      end else if (b_open && a) begin
        b_open = 0;
      end else if (b_open) begin
        b_since++;
      end
    end
    @(negedge clk);
    check(tag, bus_gnt, expect_gnt());
    rules();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    @(negedge clk);
    step('0, 0, 0, "R2 reset");
    step('1, 0, 0, "R2 reset");
    check("R2 grants low after reset", bus_gnt, '0);
    rst = 1'b0;

    step('0, 0, 0, "R2 R7 park on master 0");
    check("R2 first park", bus_gnt, 3'b001);
    step('1, 0, 0, "R6 rotate");
    check("R6 after 0 comes 1", bus_gnt, 3'b010);
    step('1, 0, 0, "R6 rotate");
    check("R6 after 1 comes 2", bus_gnt, 3'b100);
    step('1, 0, 0, "R6 wrap");
    check("R6 wrap to 0", bus_gnt, 3'b001);
    step('0, 0, 0, "R7 park");
    check("R7 park on last owner", bus_gnt, 3'b001);

    step(3'b110, 1, 0, "R5 start");
    check("R5 owner kept after start", bus_gnt, 3'b001);
    step(3'b110, 0, 0, "R4 late");
    check("R4 grants dropped", bus_gnt, 3'b000);
    step(3'b110, 0, 0, "R4 late");
    check("R4 still dropped", bus_gnt, 3'b000);
    step(3'b110, 0, 1, "R8 ack");
    check("R8 handover after ack", bus_gnt, 3'b010);

    step(3'b101, 1, 0, "R5 start");
    check("R5 owner 1 kept", bus_gnt, 3'b010);
    step(3'b101, 0, 1, "R8 on-time ack");
    check("R8 new owner next cycle", bus_gnt, 3'b100);

    step(3'b011, 1, 0, "R9 start");
    step(3'b011, 1, 1, "R9 start with ack");
    check("R9 owner kept", bus_gnt, 3'b100);
    step(3'b011, 0, 0, "R9 late restarts");
    check("R9 R4 dropped", bus_gnt, 3'b000);
    step(3'b011, 0, 1, "R8 ack");
    check("R8 R6 handover to 0", bus_gnt, 3'b001);

    for (int c = 0; c < 4000; c++) begin
      logic [NM-1:0] r;
      logic s, a;
      r = NM'($urandom);
      s = 0; a = 0;
      if (b_open) begin
        if (b_since >= b_delay) a = 1;
      end else if (bus_gnt != '0 && ($urandom % 3) == 0) begin
        s = 1;
        b_delay = 1 + ($urandom % 4);
      end
      if (($urandom % 97) == 0) begin
        rst = 1'b1;
        step(r, 0, 0, "R2 random reset");
        check("R2 random reset", bus_gnt, '0);
        rst = 1'b0;
      end else begin
        step(r, s, a, "R6 R8 random");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule